// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns one parallel character into an asynchronous serial frame on a single line that rests high when nothing is being sent. A six-bit format input sets the frame shape: number of data bits, stop length, whether a parity bit is present, and whether that bit is computed (odd or even) or held at a fixed level (mark or space). Timing is taken from a 16x oversampling enable, so one bit period is sixteen enabled clock cycles. The divider that produces the enable is outside this block.

The host presents a byte and the format, then raises the load strobe while the ready output is high. The block accepts the request on that edge and takes its own copy of the byte and the format at that point. It then sends a low start bit, the data bits starting with the least significant, the optional parity bit and the stop period. Ready stays low until the stop period has fully elapsed, so the next frame can follow with no gap.

Top module: `sertx_top`

## Requirements
- R1: After reset, and whenever no frame is in progress, the serial output is 1 and ready is 1.
- R2: A load strobe sampled while ready is 1 starts a frame: on the next cycle the output goes to 0 for one start bit and ready goes to 0.
- R3: Format bits [1:0] set the data length: 00 gives 5, 01 gives 6, 10 gives 7, 11 gives 8 bits. Data bits follow the start bit least significant first, and byte bits above the selected length are not sent.
- R4: Format bit [2] at 0 gives one stop bit. At 1 it gives one and a half stop bits for 5-bit data and two stop bits for 6, 7 or 8-bit data. Stop bits are 1.
- R5: Format bit [3] at 0 sends no parity bit. At 1 it sends one parity bit directly after the last data bit.
- R6: With bit [3] at 1 and bit [5] at 0, bit [4] at 0 selects odd parity and bit [4] at 1 selects even parity. Odd means the count of 1s across the data bits and the parity bit is odd.
- R7: With bits [3] and [5] both at 1, the parity bit is fixed: it is 1 when bit [4] is 0 and 0 when bit [4] is 1.
- R8: Every bit lasts 16 cycles in which the baud enable is high, and a half stop bit lasts 8. Cycles with the enable low do not advance the frame.
- R9: Ready returns to 1 in the cycle after the last enabled tick of the stop period. A load strobe in that cycle starts the next frame at once.
- R10: The byte and the format are captured when the load is accepted. Changes on those inputs during a frame do not alter it.
- R11: A load strobe while ready is 0 is ignored: the frame in progress is unchanged and no further frame follows it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick16_en | input | 1 | Baud enable at sixteen times the bit rate |
| line_ctl | input | 6 | Frame format: [1:0] length, [2] long stop, [3] parity on, [4] parity sense, [5] fixed parity |
| tx_data | input | 8 | Character to send |
| tx_load | input | 1 | Request to send, taken when ready is 1 |
| tx_ready | output | 1 | High when a new character can be accepted |
| tx_line | output | 1 | Serial output, 1 when idle |

## Verification
The hardest case to reach is a format or data change, or a stray load strobe, that arrives partway through a frame. It has to land while every one of the 64 format codes is active. The stimulus sends back-to-back frames over all format codes and several byte patterns. In every frame it changes the format and data inputs right after acceptance, and it pulses load with a different byte in the middle of the frame. The whole waveform is then compared, tick by tick, against a frame computed from the captured values. One further pass spaces the enable out, to show that idle enable cycles stretch the bits without changing them.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_START  = 3'd1,
    S_DATA   = 3'd2,
    S_PARITY = 3'd3,
    S_STOP   = 3'd4
  } sertx_state_e;

  // Format input, most significant field first
  typedef struct packed {
    logic       par_fixed;
    logic       par_sense;
    logic       par_on;
    logic       stop_long;
    logic [1:0] len_sel;
  } sertx_fmt_t;

endpackage

// File: rtl/sertx_fmt_dec.sv
`timescale 1ns/1ps
module sertx_fmt_dec #(
  parameter int TICKS_PER_BIT = 16,
  parameter int IDX_W         = 3,
  parameter int LIM_W         = 6
) (
  input  logic [1:0]       len_sel,
  input  logic             stop_long,
  output logic [IDX_W-1:0] last_idx,
  output logic [LIM_W-1:0] stop_lim
);

  localparam int HALF_BIT = TICKS_PER_BIT / 2;

  always_comb begin
    last_idx = IDX_W'(4) + IDX_W'(len_sel);
    if (!stop_long) begin
      stop_lim = LIM_W'(TICKS_PER_BIT);
    end else if (len_sel == 2'b00) begin
      stop_lim = LIM_W'(TICKS_PER_BIT + HALF_BIT);
    end else begin
      stop_lim = LIM_W'(2 * TICKS_PER_BIT);
    end
  end

endmodule

// File: rtl/sertx_parity.sv
`timescale 1ns/1ps
module sertx_parity #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic [1:0]        len_sel,
  input  logic              par_sense,
  input  logic              par_fixed,
  output logic              par_bit
);

  logic [DATA_W-1:0] keep;
  logic              ones_odd;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_keep
      assign keep[gi] = (gi < (5 + int'(len_sel)));
    end
  endgenerate

  assign ones_odd = ^(data & keep);

  always_comb begin
    if (par_fixed) begin
      par_bit = ~par_sense;
    end else if (par_sense) begin
      par_bit = ones_odd;
    end else begin
      par_bit = ~ones_odd;
    end
  end

endmodule

// File: rtl/sertx_seq.sv
`timescale 1ns/1ps
module sertx_seq
  import sertx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_W        = 8,
  parameter int IDX_W         = 3,
  parameter int LIM_W         = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  logic [IDX_W-1:0]  last_idx,
  input  logic [LIM_W-1:0]  stop_lim,
  input  logic              par_on,
  input  logic              par_bit,
  output logic              ready,
  output logic              line
);

  sertx_state_e      state_q, state_d;
  logic [LIM_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]  lidx_q, lidx_d;
  logic [LIM_W-1:0]  slim_q, slim_d;
  logic              pon_q, pon_d;
  logic              par_q, par_d;
  logic [LIM_W-1:0]  cur_lim;
  logic              bit_end;

  assign cur_lim = (state_q == S_STOP) ? slim_q : LIM_W'(TICKS_PER_BIT);
  assign bit_end = tick && (cnt_q == cur_lim - 1'b1);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    lidx_d  = lidx_q;
    slim_d  = slim_q;
    pon_d   = pon_q;
    par_d   = par_q;
    if (state_q == S_IDLE) begin
      if (load) begin
        state_d = S_START;
        cnt_d   = '0;
        sh_d    = data;
        lidx_d  = last_idx;
        slim_d  = stop_lim;
        pon_d   = par_on;
        par_d   = par_bit;
      end
    end else if (tick) begin
      if (bit_end) begin
        cnt_d = '0;
        case (state_q)
          S_START: begin
            state_d = S_DATA;
            idx_d   = '0;
          end
          S_DATA: begin
            sh_d = sh_q >> 1;
            if (idx_q == lidx_q) begin
              state_d = pon_q ? S_PARITY : S_STOP;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end
          S_PARITY: state_d = S_STOP;
          default:  state_d = S_IDLE;
        endcase
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      lidx_q  <= IDX_W'(4);
      slim_q  <= LIM_W'(TICKS_PER_BIT);
      pon_q   <= 1'b0;
      par_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      lidx_q  <= lidx_d;
      slim_q  <= slim_d;
      pon_q   <= pon_d;
      par_q   <= par_d;
    end
  end

  always_comb begin
    case (state_q)
      S_START:  line = 1'b0;
      S_DATA:   line = sh_q[0];
      S_PARITY: line = par_q;
      default:  line = 1'b1;
    endcase
  end

  assign ready = (state_q == S_IDLE);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE) |-> (cnt_q < cur_lim)); // R8
  AST_TICK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE && !tick) |=> ($stable(state_q) && $stable(cnt_q))); // R8
  AST_FMT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE) |=> ($stable(slim_q) && $stable(lidx_q) && $stable(pon_q) && $stable(par_q))); // R10

endmodule

// File: rtl/sertx_top.sv
`timescale 1ns/1ps
module sertx_top
  import sertx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16_en,
  input  logic [5:0]        line_ctl,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_load,
  output logic              tx_ready,
  output logic              tx_line
);

  localparam int IDX_W = $clog2(DATA_W);
  localparam int LIM_W = $clog2(2 * TICKS_PER_BIT) + 1;

  logic [1:0]       rst_pipe;
  logic             rst_n_s;
  sertx_fmt_t       fmt;
  logic [IDX_W-1:0] last_idx;
  logic [LIM_W-1:0] stop_lim;
  logic             par_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_n_s = rst_pipe[1];

  assign fmt = sertx_fmt_t'(line_ctl);

  sertx_fmt_dec #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .IDX_W        (IDX_W),
    .LIM_W        (LIM_W)
  ) u_dec (
    .len_sel  (fmt.len_sel),
    .stop_long(fmt.stop_long),
    .last_idx (last_idx),
    .stop_lim (stop_lim)
  );

  sertx_parity #(.DATA_W(DATA_W)) u_par (
    .data     (tx_data),
    .len_sel  (fmt.len_sel),
    .par_sense(fmt.par_sense),
    .par_fixed(fmt.par_fixed),
    .par_bit  (par_bit)
  );

  sertx_seq #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .DATA_W       (DATA_W),
    .IDX_W        (IDX_W),
    .LIM_W        (LIM_W)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .tick    (tick16_en),
    .load    (tx_load),
    .data    (tx_data),
    .last_idx(last_idx),
    .stop_lim(stop_lim),
    .par_on  (fmt.par_on),
    .par_bit (par_bit),
    .ready   (tx_ready),
    .line    (tx_line)
  );

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n_s)
    (tx_load && tx_ready) |=> (!tx_line && !tx_ready)); // R2
  AST_READY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(tx_ready) |-> $past(tx_line)); // R9
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n_s)
    tx_ready |-> tx_line); // R1

endmodule

// File: tb/tb_sertx_top.sv
`timescale 1ns/1ps
module tb_sertx_top;

  logic       clk;
  logic       rst_n;
  logic       tick16_en;
  logic [5:0] line_ctl;
  logic [7:0] tx_data;
  logic       tx_load;
  logic       tx_ready;
  logic       tx_line;

  int checks = 0;
  int errors = 0;
  int tick_div = 1;
  int tick_cnt = 0;
  bit done = 0;

  sertx_top dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick16_en(tick16_en),
    .line_ctl (line_ctl),
    .tx_data  (tx_data),
    .tx_load  (tx_load),
    .tx_ready (tx_ready),
    .tx_line  (tx_line)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Enable generator, driven away from the active edge
  always @(negedge clk) begin
    if (tick_cnt >= tick_div - 1) begin
      tick_cnt  <= 0;
      tick16_en <= 1'b1;
    end else begin
      tick_cnt  <= tick_cnt + 1;
      tick16_en <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int n_bits(input logic [5:0] c);
    return 5 + int'(c[1:0]);
  endfunction

  function automatic int frame_ticks(input logic [5:0] c);
    int n = n_bits(c);
    int st = !c[2] ? 16 : (n == 5 ? 24 : 32);
    return 16 * (1 + n + int'(c[3])) + st;
  endfunction

  function automatic logic exp_line(input int ts, input logic [7:0] d, input logic [5:0] c);
    int n = n_bits(c);
    int pos = ts / 16;
    logic ones = 1'b0;
    logic par;
    for (int i = 0; i < n; i++) ones ^= d[i];
    par = c[5] ? ~c[4] : (c[4] ? ones : ~ones);
    if (pos == 0) return 1'b0;
    if (pos <= n) return d[pos-1];
    if (c[3] && pos == n + 1) return par;
    return 1'b1;
  endfunction

  // Called at a negedge with ready high; returns at the negedge where ready is back
  task automatic send_frame(input logic [7:0] d, input logic [5:0] c, input string tag);
    int ts = 0;
    int t_end = frame_ticks(c);
    int mism = 0;
    int bad_ts = -1;
    int bad_act = 0;
    int bad_exp = 0;
    tx_data  = d;
    line_ctl = c;
    tx_load  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tx_load  = 1'b0;
    // R10: inputs change right after capture
    tx_data  = ~d;
    line_ctl = c ^ 6'h2D;
    while (1) begin
      logic el = (ts < t_end) ? exp_line(ts, d, c) : 1'b1;
      logic er = (ts >= t_end);
      if (tx_line !== el || tx_ready !== er) begin
        mism++;
        if (bad_ts < 0) begin
          bad_ts  = ts;
          bad_act = {tx_ready, tx_line};
          bad_exp = {er, el};
        end
      end
      // R11: stray load mid-frame with different byte and format
      if (ts == 40) begin
        tx_load  = 1'b1;
        tx_data  = d ^ 8'h5A;
        line_ctl = ~c;
      end else begin
        tx_load  = 1'b0;
      end
      if (ts >= t_end) break;
      @(posedge clk);
      if (tick16_en) ts++;
      @(negedge clk);
    end
    tx_load = 1'b0;
    if (mism != 0)
      $display("FAIL detail %s ctl=%0h data=%0h first tick %0d", tag, c, d, bad_ts);
    check(mism == 0, tag, bad_act, bad_exp);
  endtask

  initial begin
    rst_n     = 1'b0;
    tx_load   = 1'b0;
    tx_data   = 8'h00;
    line_ctl  = 6'h00;
    tick16_en = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(tx_line === 1'b1, "R1 idle line", tx_line, 1);
    check(tx_ready === 1'b1, "R1 idle ready", tx_ready, 1);

    // Full sweep, back-to-back: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11
    for (int di = 0; di < 4; di++) begin
      logic [7:0] dv;
      case (di)
        0: dv = 8'h00;
        1: dv = 8'hFF;
        2: dv = 8'hA5;
        default: dv = 8'h3C;
      endcase
      for (int ci = 0; ci < 64; ci++) begin
        send_frame(dv ^ 8'(ci * 7), 6'(ci), "R2 R3 R4 R5 R6 R7 R9 R10 frame");
      end
    end

    // R11: nothing follows after the stray load
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check(tx_line === 1'b1 && tx_ready === 1'b1, "R11 idle after frame",
            {tx_ready, tx_line}, 3);
    end

    // R8: sparse enable stretches bits
    tick_div = 3;
    repeat (6) @(negedge clk);
    send_frame(8'h96, 6'h3F, "R8 sparse ticks");
    send_frame(8'h4B, 6'h0C, "R8 sparse ticks");
    send_frame(8'h17, 6'h04, "R8 sparse ticks half stop");
    send_frame(8'hE2, 6'h2B, "R8 sparse ticks");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule